// File: doc/BRIEF.md
# Ping-Pong Transpose Buffer Arbiter

This block sits between two one-dimensional transform stages. It shares two 8x8 block buffers between them. The buffers are external dual-port synchronous RAMs, and the block drives their ports. The upstream stage (the writer) asks for a free buffer and streams one block into it in row order. The downstream stage (the reader) asks for a filled buffer and drains it in column order. The reader therefore receives every block transposed.

Each buffer is in one of three ownership states: empty, being filled, or full (held by the reader until it is drained). Grants are given from these states. Both ports take buffers in a strict 0, 1, 0, 1 order. The writer can fill one buffer while the reader drains the other. Handover at a block boundary costs no cycle, so with both stages streaming, one 64-sample block moves through every 64 clocks.

The block generates the write address, the read address and the per-buffer enables. It also returns the read word from whichever buffer was addressed one clock earlier.

Top module: `tpb_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released, `wr_gnt`, `rd_gnt`, `ram_we`, `ram_re` and `rd_q_vld` are all 0. Assertion of `rst_n` clears them without waiting for a clock, and both buffers become empty.
- R2: With both buffers empty and the writer idle, raising `wr_req` before a clock edge makes `wr_gnt` 1 with `wr_sel` = 0 after that edge.
- R3: The k-th accepted sample of a block (k = 0..63, row r = k/8, column c = k%8) is written in the same cycle to address r*8+c. `ram_we` is one-hot, with bit `wr_sel` set, and `ram_wdata` equals `wr_data`.
- R4: The k-th read strobe of a block reads address (k%8)*8 + k/8 in the same cycle, with `ram_re` one-hot on bit `rd_sel`. This is column order.
- R5: One cycle after a read strobe, `rd_q_vld` is 1 and `rd_q` equals the read data of the buffer that was strobed.
- R6: The writer takes buffers strictly in the order 0, 1, 0, 1, and so does the reader. `wr_sel` and `rd_sel` name the buffer each one holds.
- R7: `rd_gnt` stays 0 while no buffer is full, whatever `rd_req` does.
- R8: `wr_gnt` stays 0 while both buffers are occupied (being filled, full, or being read).
- R9: If `wr_req` is held and the next buffer is free, `wr_gnt` stays 1 across a block boundary and `wr_sel` switches in the cycle after the 64th write. The reader behaves the same way at the 64th read.
- R10: `wr_vld` without `wr_gnt`, and `rd_en` without `rd_gnt`, do not pulse `ram_we` or `ram_re`.
- R11: The writer and the reader never hold the same buffer, and they can both move data in the same cycle.
- R12: A buffer becomes full at the edge that takes its 64th write. A reader that is requesting is granted that buffer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Writer asks for a free buffer |
| wr_vld | input | 1 | Writer sample valid (used only while granted) |
| wr_data | input | 14 | Writer sample |
| wr_gnt | output | 1 | Writer owns a buffer |
| wr_sel | output | 1 | Buffer owned by the writer |
| rd_req | input | 1 | Reader asks for a full buffer |
| rd_en | input | 1 | Reader read strobe (used only while granted) |
| rd_gnt | output | 1 | Reader owns a buffer |
| rd_sel | output | 1 | Buffer owned by the reader |
| ram_we | output | 2 | Per-buffer write enable |
| ram_waddr | output | 6 | Write address, row order |
| ram_wdata | output | 14 | Write data |
| ram_re | output | 2 | Per-buffer read enable |
| ram_raddr | output | 6 | Read address, column order |
| ram_rdata0 | input | 14 | Registered read data of buffer 0 |
| ram_rdata1 | input | 14 | Registered read data of buffer 1 |
| rd_q | output | 14 | Read word returned to the reader |
| rd_q_vld | output | 1 | `rd_q` is valid |

## Verification
The RAM strobes and addresses are combinational from the strobe and the current grant, so they are due in the same cycle. The bench samples them at the falling edge of the cycle in which it drives the strobe. Grants and buffer selection are registered and are due one cycle after the edge that causes them. The bench records them at the falling edge that follows the last sample of a block. `rd_q` passes through the bench's one-cycle RAM model and the block's select register, so each read word is compared at the falling edge one cycle after its strobe, against the block's pattern at the transposed address.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  // Ownership state of one block buffer
  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_FULL  = 2'd2
  } buf_st_t;

  localparam int NUM_BUF = 2;

endpackage

// File: rtl/tpb_rst_sync.sv
module tpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tpb_cursor.sv
module tpb_cursor #(
  parameter int BLK_DIM   = 8,
  parameter bit TRANSPOSE = 1'b0,
  localparam int DEPTH    = BLK_DIM * BLK_DIM,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam int LINE_W = $clog2(BLK_DIM);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      cnt_d = (cnt_q == ADDR_W'(DEPTH - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == ADDR_W'(DEPTH - 1));

  generate
    if (TRANSPOSE) begin : g_col
      // low count bits pick the row, high bits pick the column
      assign addr = {cnt_q[LINE_W-1:0], cnt_q[ADDR_W-1:LINE_W]};
    end else begin : g_row
      assign addr = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/tpb_owner.sv
module tpb_owner
  import tpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic wr_step,
  input  logic wr_last,
  input  logic rd_req,
  input  logic rd_step,
  input  logic rd_last,
  output logic wr_gnt,
  output logic wr_sel,
  output logic rd_gnt,
  output logic rd_sel
);

  buf_st_t st_q [NUM_BUF];
  buf_st_t st_d [NUM_BUF];

  logic wr_act_q, wr_act_d, wr_buf_q, wr_buf_d;
  logic rd_act_q, rd_act_d, rd_buf_q, rd_buf_d;
  logic wr_done, rd_done, wr_tgt, rd_tgt, wr_claim, rd_claim;
  logic [NUM_BUF-1:0] free_w;
  logic [NUM_BUF-1:0] ready_r;

  always_comb begin
    wr_done = wr_act_q & wr_step & wr_last;
    rd_done = rd_act_q & rd_step & rd_last;
    wr_tgt  = wr_buf_q ^ wr_done;
    rd_tgt  = rd_buf_q ^ rd_done;
  end

  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      // a buffer counts as free / ready if it becomes so at this edge
      assign free_w[b]  = (st_q[b] == BUF_EMPTY) | (rd_done & (rd_buf_q == 1'(b)));
      assign ready_r[b] = (st_q[b] == BUF_FULL)  | (wr_done & (wr_buf_q == 1'(b)));

      always_comb begin
        st_d[b] = st_q[b];
        if (rd_done && rd_buf_q == 1'(b)) st_d[b] = BUF_EMPTY;
        if (wr_done && wr_buf_q == 1'(b)) st_d[b] = BUF_FULL;
        if (wr_claim && wr_tgt == 1'(b))  st_d[b] = BUF_FILL;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[b] <= BUF_EMPTY;
        end else begin
          st_q[b] <= st_d[b];
        end
      end
    end
  endgenerate

  always_comb begin
    wr_claim = wr_req & free_w[wr_tgt]  & (~wr_act_q | wr_done);
    rd_claim = rd_req & ready_r[rd_tgt] & (~rd_act_q | rd_done);
    wr_act_d = (wr_act_q & ~wr_done) | wr_claim;
    rd_act_d = (rd_act_q & ~rd_done) | rd_claim;
    wr_buf_d = wr_tgt;
    rd_buf_d = rd_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      wr_buf_q <= 1'b0;
      rd_act_q <= 1'b0;
      rd_buf_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act_d;
      wr_buf_q <= wr_buf_d;
      rd_act_q <= rd_act_d;
      rd_buf_q <= rd_buf_d;
    end
  end

  assign wr_gnt = wr_act_q;
  assign wr_sel = wr_buf_q;
  assign rd_gnt = rd_act_q;
  assign rd_sel = rd_buf_q;

  // R11
  owners_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act_q && rd_act_q) |-> (wr_buf_q != rd_buf_q));

  // R8
  writer_holds_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act_q |-> (st_q[wr_buf_q] == BUF_FILL));

  // R7
  reader_holds_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_q |-> (st_q[rd_buf_q] == BUF_FULL));

  // R6
  wr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act_q && wr_step && wr_last) |=> (wr_buf_q != $past(wr_buf_q)));

  // R6
  rd_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act_q && rd_step && rd_last) |=> (rd_buf_q != $past(rd_buf_q)));

endmodule

// File: rtl/tpb_rd_mux.sv
module tpb_rd_mux #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] rdata0,
  input  logic [DATA_W-1:0] rdata1,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_q_vld
);

  logic sel_q, sel_d, vld_q, vld_d;

  always_comb begin
    vld_d = rd_fire;
    sel_d = rd_fire ? rd_sel : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sel_q <= sel_d;
    end
  end

  assign rd_q     = sel_q ? rdata1 : rdata0;
  assign rd_q_vld = vld_q;

endmodule

// File: rtl/tpb_arbiter.sv
module tpb_arbiter #(
  parameter int  DATA_W  = 14,
  parameter int  BLK_DIM = 8,
  localparam int ADDR_W  = $clog2(BLK_DIM * BLK_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_gnt,
  output logic              wr_sel,
  input  logic              rd_req,
  input  logic              rd_en,
  output logic              rd_gnt,
  output logic              rd_sel,
  output logic [1:0]        ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [1:0]        ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata0,
  input  logic [DATA_W-1:0] ram_rdata1,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_q_vld
);

  logic rst_sync_n;
  logic wr_fire, rd_fire, wr_last, rd_last;

  tpb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_fire = wr_vld & wr_gnt;
  assign rd_fire = rd_en & rd_gnt;

  tpb_owner u_owner (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_req  (wr_req),
    .wr_step (wr_fire),
    .wr_last (wr_last),
    .rd_req  (rd_req),
    .rd_step (rd_fire),
    .rd_last (rd_last),
    .wr_gnt  (wr_gnt),
    .wr_sel  (wr_sel),
    .rd_gnt  (rd_gnt),
    .rd_sel  (rd_sel)
  );

  tpb_cursor #(.BLK_DIM(BLK_DIM), .TRANSPOSE(1'b0)) u_wcur (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (wr_fire),
    .addr  (ram_waddr),
    .last  (wr_last)
  );

  tpb_cursor #(.BLK_DIM(BLK_DIM), .TRANSPOSE(1'b1)) u_rcur (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (rd_fire),
    .addr  (ram_raddr),
    .last  (rd_last)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_en
      assign ram_we[b] = wr_fire & (wr_sel == 1'(b));
      assign ram_re[b] = rd_fire & (rd_sel == 1'(b));
    end
  endgenerate

  assign ram_wdata = wr_data;

  tpb_rd_mux #(.DATA_W(DATA_W)) u_rmux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_fire  (rd_fire),
    .rd_sel   (rd_sel),
    .rdata0   (ram_rdata0),
    .rdata1   (ram_rdata1),
    .rd_q     (rd_q),
    .rd_q_vld (rd_q_vld)
  );

  // R11
  port_buf_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|ram_we) && (|ram_re)) |-> (ram_we != ram_re));

  // R4
  rd_row_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(rd_gnt) && rd_en) |-> (ram_raddr == '0));

endmodule

// File: tb/tb_tpb_arbiter.sv
module tb_tpb_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_req, wr_vld, rd_req, rd_en;
  logic [13:0] wr_data;
  logic        wr_gnt, wr_sel, rd_gnt, rd_sel;
  logic [1:0]  ram_we, ram_re;
  logic [5:0]  ram_waddr, ram_raddr;
  logic [13:0] ram_wdata, rd_q;
  logic [13:0] rdat0, rdat1;
  logic        rd_q_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic s_wg, s_ws, s_rg, s_rs;

  always #10 clk = ~clk;

  tpb_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_vld(wr_vld), .wr_data(wr_data),
    .wr_gnt(wr_gnt), .wr_sel(wr_sel),
    .rd_req(rd_req), .rd_en(rd_en),
    .rd_gnt(rd_gnt), .rd_sel(rd_sel),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ram_rdata0(rdat0), .ram_rdata1(rdat1),
    .rd_q(rd_q), .rd_q_vld(rd_q_vld)
  );

  // Bench model of the two synchronous dual-port RAMs
  logic [13:0] mem0 [64];
  logic [13:0] mem1 [64];
  always @(posedge clk) begin
    if (ram_we[0]) mem0[ram_waddr] <= ram_wdata;
    if (ram_we[1]) mem1[ram_waddr] <= ram_wdata;
    if (ram_re[0]) rdat0 <= mem0[ram_raddr];
    if (ram_re[1]) rdat1 <= mem1[ram_raddr];
  end

  // seed, write buffer, read buffer
  localparam logic [17:0] VEC [4] = '{
    {16'h0011, 1'b0, 1'b0},
    {16'h2A5C, 1'b1, 1'b1},
    {16'h7F03, 1'b0, 1'b0},
    {16'hC3E9, 1'b1, 1'b1}
  };

  function automatic logic [13:0] pat(input logic [15:0] s, input int a);
    return 14'(int'(s) * 37 + a * 113 + (a << 7));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic await_w(input logic sel);
    for (int i = 0; i < 8 && !wr_gnt; i++) step();
    chk(wr_gnt == 1'b1, "R6 wr_gnt", int'(wr_gnt), 1);
    chk(wr_sel == sel, "R6 wr_sel", int'(wr_sel), int'(sel));
  endtask

  task automatic await_r(input logic sel);
    for (int i = 0; i < 8 && !rd_gnt; i++) step();
    chk(rd_gnt == 1'b1, "R12 rd_gnt", int'(rd_gnt), 1);
    chk(rd_sel == sel, "R6 rd_sel", int'(rd_sel), int'(sel));
  endtask

  // 64 cycles of writes and/or reads; starts just after a rising edge
  task automatic stream(input logic dw, input logic [15:0] ws, input logic wsel,
                        input logic dr, input logic [15:0] rs, input logic rsel);
    int pa;
    pa = 0;
    for (int k = 0; k < 64; k++) begin
      wr_vld  = dw;
      wr_data = pat(ws, k);
      rd_en   = dr;
      @(negedge clk);
      if (dw) begin
        chk(ram_we == (2'b01 << wsel), "R3 ram_we", int'(ram_we), int'(2'b01 << wsel));
        chk(ram_waddr == 6'(k), "R3 ram_waddr", int'(ram_waddr), k);
      end
      if (dr) begin
        chk(ram_re == (2'b01 << rsel), "R4 ram_re", int'(ram_re), int'(2'b01 << rsel));
        chk(int'(ram_raddr) == (k % 8) * 8 + k / 8, "R4 ram_raddr",
            int'(ram_raddr), (k % 8) * 8 + k / 8);
        if (k > 0) begin
          chk(rd_q_vld == 1'b1, "R5 rd_q_vld", int'(rd_q_vld), 1);
          chk(rd_q == pat(rs, pa), "R5 rd_q", int'(rd_q), int'(pat(rs, pa)));
        end
        pa = (k % 8) * 8 + k / 8;
      end
      step();
    end
    wr_vld = 1'b0;
    rd_en  = 1'b0;
    @(negedge clk);
    if (dr) begin
      chk(rd_q_vld == 1'b1, "R5 rd_q_vld last", int'(rd_q_vld), 1);
      chk(rd_q == pat(rs, 63), "R5 rd_q last", int'(rd_q), int'(pat(rs, 63)));
    end
    s_wg = wr_gnt; s_ws = wr_sel; s_rg = rd_gnt; s_rs = rd_sel;
    step();
  endtask

  task automatic chk_idle(input string req);
    chk(wr_gnt == 1'b0, req, int'(wr_gnt), 0);
    chk(rd_gnt == 1'b0, req, int'(rd_gnt), 0);
    chk(ram_we == 2'b00, req, int'(ram_we), 0);
    chk(ram_re == 2'b00, req, int'(ram_re), 0);
    chk(rd_q_vld == 1'b0, req, int'(rd_q_vld), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_req = 1'b0; wr_vld = 1'b0; rd_req = 1'b0; rd_en = 1'b0;
    wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    step();
    rst_n = 1'b1;
    repeat (3) step();
    @(negedge clk);
    chk_idle("R1 after reset");
    step();

    // R7 and R10: requests and strobes with nothing full and nothing granted
    rd_req = 1'b1; rd_en = 1'b1; wr_vld = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rd_gnt == 1'b0, "R7 rd_gnt", int'(rd_gnt), 0);
      chk(ram_re == 2'b00, "R10 ram_re", int'(ram_re), 0);
      chk(ram_we == 2'b00, "R10 ram_we", int'(ram_we), 0);
      step();
    end
    rd_req = 1'b0; rd_en = 1'b0; wr_vld = 1'b0;

    // R2: first grant one edge after the request, on buffer 0
    wr_req = 1'b1;
    @(negedge clk);
    chk(wr_gnt == 1'b0, "R2 before edge", int'(wr_gnt), 0);
    step();
    chk(wr_gnt == 1'b1, "R2 wr_gnt", int'(wr_gnt), 1);
    chk(wr_sel == 1'b0, "R2 wr_sel", int'(wr_sel), 0);

    // Vector table: serial write then transposed read, strict alternation
    for (int i = 0; i < 4; i++) begin
      wr_req = 1'b1;
      await_w(VEC[i][1]);
      wr_req = 1'b0;
      stream(1'b1, VEC[i][17:2], VEC[i][1], 1'b0, 16'h0, 1'b0);
      rd_req = 1'b1;
      await_r(VEC[i][0]);
      rd_req = 1'b0;
      stream(1'b0, 16'h0, 1'b0, 1'b1, VEC[i][17:2], VEC[i][0]);
    end

    // Pipeline with both requests held
    wr_req = 1'b1; rd_req = 1'b1;
    await_w(1'b0);
    stream(1'b1, 16'h1234, 1'b0, 1'b0, 16'h0, 1'b0);
    chk(s_wg == 1'b1 && s_ws == 1'b1, "R9 wr handover", int'({s_wg, s_ws}), 3);
    chk(s_rg == 1'b1 && s_rs == 1'b0, "R12 rd grant next cycle", int'({s_rg, s_rs}), 2);
    stream(1'b1, 16'h5A5A, 1'b1, 1'b0, 16'h0, 1'b0);
    chk(s_wg == 1'b0, "R8 both occupied", int'(s_wg), 0);
    wr_vld = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(ram_we == 2'b00, "R10 ungranted write", int'(ram_we), 0);
      step();
    end
    wr_vld = 1'b0;
    stream(1'b0, 16'h0, 1'b0, 1'b1, 16'h1234, 1'b0);
    chk(s_rg == 1'b1 && s_rs == 1'b1, "R9 rd handover", int'({s_rg, s_rs}), 3);
    chk(s_wg == 1'b1 && s_ws == 1'b0, "R6 writer reclaims 0", int'({s_wg, s_ws}), 2);
    // R11: write buffer 0 while reading buffer 1
    stream(1'b1, 16'h0F0F, 1'b0, 1'b1, 16'h5A5A, 1'b1);
    chk(s_wg == 1'b1 && s_ws == 1'b1, "R11 writer next", int'({s_wg, s_ws}), 3);
    chk(s_rg == 1'b1 && s_rs == 1'b0, "R11 reader next", int'({s_rg, s_rs}), 2);
    wr_req = 1'b0;
    stream(1'b0, 16'h0, 1'b0, 1'b1, 16'h0F0F, 1'b0);
    chk(s_rg == 1'b0, "R7 next not full", int'(s_rg), 0);

    // R1: asynchronous reset while the writer holds a buffer
    rst_n = 1'b0;
    #1;
    chk(wr_gnt == 1'b0, "R1 async clear", int'(wr_gnt), 0);
    rd_req = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (3) step();
    @(negedge clk);
    chk_idle("R1 after second reset");
    step();
    wr_req = 1'b1;
    step();
    chk(wr_gnt == 1'b1 && wr_sel == 1'b0, "R2 after reset", int'({wr_gnt, wr_sel}), 2);
    wr_req = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule